// File: doc/BRIEF.md
# Conditional Skip Decision Unit

This unit decides whether an instruction from the conditional-skip group of an 18-bit, ones'-complement machine should cause the next instruction to be skipped. The word's top five bits identify the group. The lower bits hold independent test enables, and each enable looks at a different piece of machine state: the sign of the accumulator, whether the accumulator is zero, the sign of the IO register, the overflow flag, one of six program flags and one of six sense switches.

Every enabled test that is true contributes to the result, and the contributions are ORed together. A reverse bit can then invert the combined result, which gives the "skip unless" forms and an unconditional skip. The sequencer asserts `valid` for one cycle with the instruction word. One clock later the unit answers with a one-cycle `skip` pulse.

The unit also holds the overflow flag. The arithmetic side sets this flag, and an instruction that tests it clears it.

Top module: `skip_eval`

## Requirements
- R1: While `rst` is high, the clock edge drives `skip` and `ov` to 0.
- R2: `skip` can be 1 only in the cycle right after a cycle that had `valid` high and `instr[17:13]` equal to 5'b11010. After any other cycle it is 0, and it never stays high into a second cycle without a new qualifying strobe.
- R3: When `instr[8]` is set, the accumulator-negative test is true if `ac[17]` is 1.
- R4: When `instr[7]` is set, the accumulator-positive test is true if `ac[17]` is 0.
- R5: When `instr[6]` is set, the accumulator-zero test is true only if all 18 bits of `ac` are 0. The all-ones pattern, which is minus zero, does not satisfy it.
- R6: When `instr[10]` is set, the IO test is true if `io[17]` is 0.
- R7: When `instr[9]` is set, the overflow test is true if `ov` is 0. On the edge that registers a valid group instruction with this bit set, `ov` is cleared.
- R8: Field `instr[2:0]` selects a flag test, true when the selected flag is 0. Value 0 disables the test. Values 1 to 6 select `flags[n-1]`. Value 7 is true only if all six flags are 0.
- R9: Field `instr[5:3]` selects a switch test on `switches`. It uses the same encoding as R8.
- R10: The enabled tests are ORed together. A group instruction with no test enabled and `instr[12]` clear gives no skip.
- R11: `instr[12]` inverts the ORed result, so with no test enabled it gives an unconditional skip.
- R12: A high `ov_set` sets `ov` on the next edge, unless the clear of R7 happens on that same edge, in which case the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Instruction strobe, one cycle per instruction |
| instr | input | 18 | Instruction word; bit 17 is the most significant |
| ac | input | 18 | Accumulator value |
| io | input | 18 | IO register value |
| ov_set | input | 1 | Request from arithmetic to set overflow |
| flags | input | 6 | Program flags 1..6 in bits 0..5 |
| switches | input | 6 | Sense switches 1..6 in bits 0..5 |
| skip | output | 1 | Registered one-cycle skip request |
| ov | output | 1 | Overflow flag |

## Verification
Both `skip` and `ov` are due exactly one clock after the cycle that presents the strobe or the set request, because each passes through a single register. The bench drives every stimulus on a falling edge and compares both outputs on the following falling edge. A software model of the flag decides what `ov` was when it was tested and what it becomes. Idle cycles that follow a skip are checked as well, which shows the pulse lasts a single cycle.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;

  // Decoded view of the low 13 bits of a skip-group word (bit 12 first).
  typedef struct packed {
    logic       invert;    // bit 12
    logic       spare;     // bit 11
    logic       io_pos;    // bit 10
    logic       ov_test;   // bit 9
    logic       ac_neg;    // bit 8
    logic       ac_pos;    // bit 7
    logic       ac_zero;   // bit 6
    logic [2:0] sw_sel;    // bits 5:3
    logic [2:0] fl_sel;    // bits 2:0
  } skip_fields_t;

  localparam int FIELD_W = $bits(skip_fields_t);

endpackage

// File: rtl/skip_sel.sv
// Selects one of N inputs (or all of them) and reports whether the pick is zero.
module skip_sel #(
  parameter int N     = 6,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0]     bits,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam logic [SEL_W-1:0] SEL_ALL = {SEL_W{1'b1}};

  logic [N-1:0] pick;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign pick[i] = (sel == SEL_W'(i + 1)) && !bits[i];
  end

  assign hit = (|pick) || ((sel == SEL_ALL) && (bits == '0));
endmodule

// File: rtl/skip_cond.sv
// Combines the enabled tests and applies the invert bit.
module skip_cond
  import skip_eval_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  skip_fields_t      f,
  input  logic [WORD_W-1:0] ac,
  input  logic              io_sign,
  input  logic              ov,
  input  logic              fl_hit,
  input  logic              sw_hit,
  output logic              decide
);
  localparam int SIGN = WORD_W - 1;

  logic [5:0] terms;

  always_comb begin
    terms[0] = f.ac_neg  &&  ac[SIGN];
    terms[1] = f.ac_pos  && !ac[SIGN];
    terms[2] = f.ac_zero && (ac == '0);
    terms[3] = f.io_pos  && !io_sign;
    terms[4] = f.ov_test && !ov;
    terms[5] = fl_hit || sw_hit;
    decide   = (|terms) ^ f.invert;
  end
endmodule

// File: rtl/skip_ovf.sv
// Overflow flag: a test clears it, and the clear has priority over a set.
module skip_ovf (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic ov
);
  always_ff @(posedge clk) begin
    if (rst)      ov <= 1'b0;
    else if (clr) ov <= 1'b0;
    else if (set) ov <= 1'b1;
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_eval_pkg::*;
#(
  parameter int          WORD_W    = 18,
  parameter int          N_SEL     = 6,
  parameter int          SEL_W     = 3,
  parameter int          OPC_W     = 5,
  parameter logic [4:0]  GROUP_OPC = 5'b11010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] io,
  input  logic              ov_set,
  input  logic [N_SEL-1:0]  flags,
  input  logic [N_SEL-1:0]  switches,
  output logic              skip,
  output logic              ov
);
  localparam int SIGN = WORD_W - 1;

  skip_fields_t f;
  logic         in_group;
  logic         take;
  logic         fl_hit;
  logic         sw_hit;
  logic         decide;
  logic         unused_bits;

  assign f           = skip_fields_t'(instr[FIELD_W-1:0]);
  assign in_group    = (instr[WORD_W-1 -: OPC_W] == GROUP_OPC);
  assign take        = valid && in_group;
  assign unused_bits = ^{io[SIGN-1:0], f.spare};

  skip_sel #(.N(N_SEL), .SEL_W(SEL_W)) u_flag_sel (
    .bits(flags), .sel(f.fl_sel), .hit(fl_hit)
  );

  skip_sel #(.N(N_SEL), .SEL_W(SEL_W)) u_sw_sel (
    .bits(switches), .sel(f.sw_sel), .hit(sw_hit)
  );

  skip_cond #(.WORD_W(WORD_W)) u_cond (
    .f(f), .ac(ac), .io_sign(io[SIGN]), .ov(ov),
    .fl_hit(fl_hit), .sw_hit(sw_hit), .decide(decide)
  );

  skip_ovf u_ovf (
    .clk(clk), .rst(rst), .clr(take && f.ov_test), .set(ov_set), .ov(ov)
  );

  always_ff @(posedge clk) begin
    if (rst) skip <= 1'b0;
    else     skip <= take && decide;
  end
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
  parameter int         WORD_W    = 18,
  parameter int         OPC_W     = 5,
  parameter logic [4:0] GROUP_OPC = 5'b11010
) (
  input logic              clk,
  input logic              rst,
  input logic              valid,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] ac,
  input logic              ov_set,
  input logic              skip,
  input logic              ov
);
  logic grp;
  assign grp = valid && (instr[WORD_W-1 -: OPC_W] == GROUP_OPC);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!skip && !ov));

  assert_skip_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    skip |-> $past(grp));

  assert_neg_ac_skips_R3: assert property (@(posedge clk) disable iff (rst)
    (grp && !instr[12] && instr[8] && ac[WORD_W-1]) |=> skip);

  assert_ov_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    (grp && instr[9]) |=> !ov);

  assert_none_no_skip_R10: assert property (@(posedge clk) disable iff (rst)
    (grp && instr[12:0] == 13'd0) |=> !skip);

  assert_reverse_always_R11: assert property (@(posedge clk) disable iff (rst)
    (grp && instr[12] && instr[11:0] == 12'd0) |=> skip);

  assert_ov_set_R12: assert property (@(posedge clk) disable iff (rst)
    (ov_set && !(grp && instr[9])) |=> ov);
endmodule

bind skip_eval skip_eval_chk #(.WORD_W(WORD_W), .OPC_W(OPC_W), .GROUP_OPC(GROUP_OPC)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .instr(instr), .ac(ac),
  .ov_set(ov_set), .skip(skip), .ov(ov)
);

// File: tb/test_skip_eval.sv
module test_skip_eval;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [17:0] instr = '0;
  logic [17:0] ac = '0;
  logic [17:0] io = '0;
  logic        ov_set = 1'b0;
  logic [5:0]  flags = '0;
  logic [5:0]  switches = '0;
  logic        skip;
  logic        ov;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  m_ov     = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  skip_eval i_skip_eval (
    .clk(clk), .rst(rst), .valid(valid), .instr(instr), .ac(ac), .io(io),
    .ov_set(ov_set), .flags(flags), .switches(switches), .skip(skip), .ov(ov)
  );

  function automatic bit sel_hit(logic [2:0] s, logic [5:0] b);
    if (s == 3'd0) return 1'b0;
    if (s == 3'd7) return (b == 6'd0);
    return !b[s - 1];
  endfunction

  function automatic bit model_skip(logic v, logic [17:0] w, logic [17:0] a,
                                    logic [17:0] i, bit o, logic [5:0] fl,
                                    logic [5:0] sw);
    bit c;
    if (!v || w[17:13] != 5'b11010) return 1'b0;
    c = 1'b0;
    if (w[8] && a[17])     c = 1'b1;
    if (w[7] && !a[17])    c = 1'b1;
    if (w[6] && a == '0)   c = 1'b1;
    if (w[10] && !i[17])   c = 1'b1;
    if (w[9] && !o)        c = 1'b1;
    if (sel_hit(w[2:0], fl)) c = 1'b1;
    if (sel_hit(w[5:3], sw)) c = 1'b1;
    return c ^ w[12];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then compare both outputs one cycle later.
  task automatic step(string tag, logic v, logic [17:0] w, logic [17:0] a,
                      logic [17:0] i, logic [5:0] fl, logic [5:0] sw, logic os);
    bit exp_s;
    bit clr;
    valid = v; instr = w; ac = a; io = i; flags = fl; switches = sw; ov_set = os;
    exp_s = model_skip(v, w, a, i, m_ov, fl, sw);
    clr   = v && w[17:13] == 5'b11010 && w[9];
    if (clr)     m_ov = 1'b0;
    else if (os) m_ov = 1'b1;
    @(negedge clk);
    check({tag, " skip"}, skip, exp_s);
    check({tag, " ov"}, ov, m_ov);
  endtask

  localparam logic [17:0] GRP = 18'o640000;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    check("R1 reset skip", skip, 1'b0);
    check("R1 reset ov", ov, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    step("R10 no test",        1, GRP,            18'o0,      18'o0, 6'o77, 6'o77, 0);
    step("R11 unconditional",  1, GRP | 18'o010000, 18'o1,    18'o0, 6'o77, 6'o77, 0);
    step("R2 pulse ends",      0, GRP | 18'o010000, 18'o1,    18'o0, 6'o77, 6'o77, 0);
    step("R2 other group",     1, 18'o600000 | 18'o010000, 18'o0, 18'o0, 6'o0, 6'o0, 0);
    step("R3 ac negative",     1, GRP | 18'o000400, 18'o400000, 18'o0, 6'o77, 6'o77, 0);
    step("R3 ac not negative", 1, GRP | 18'o000400, 18'o000001, 18'o0, 6'o77, 6'o77, 0);
    step("R4 ac positive",     1, GRP | 18'o000200, 18'o377777, 18'o0, 6'o77, 6'o77, 0);
    step("R4 ac negative",     1, GRP | 18'o000200, 18'o400000, 18'o0, 6'o77, 6'o77, 0);
    step("R5 plus zero",       1, GRP | 18'o000100, 18'o0,      18'o0, 6'o77, 6'o77, 0);
    step("R5 minus zero",      1, GRP | 18'o000100, 18'o777777, 18'o0, 6'o77, 6'o77, 0);
    step("R6 io positive",     1, GRP | 18'o002000, 18'o1, 18'o377777, 6'o77, 6'o77, 0);
    step("R6 io negative",     1, GRP | 18'o002000, 18'o1, 18'o400000, 6'o77, 6'o77, 0);
    step("R12 ov set",         0, 18'o0, 18'o1, 18'o0, 6'o77, 6'o77, 1);
    step("R7 test ov set",     1, GRP | 18'o001000, 18'o1, 18'o0, 6'o77, 6'o77, 0);
    step("R7 test ov clear",   1, GRP | 18'o001000, 18'o1, 18'o0, 6'o77, 6'o77, 0);
    step("R7 clear beats set", 1, GRP | 18'o001000, 18'o1, 18'o0, 6'o77, 6'o77, 1);
    step("R12 set no test",    1, GRP | 18'o000100, 18'o1, 18'o0, 6'o77, 6'o77, 1);
    for (int s = 0; s < 8; s++) begin
      step("R8 flag one low",  1, GRP | 18'(s), 18'o1, 18'o0, 6'o73, 6'o77, 0);
      step("R8 flag all high", 1, GRP | 18'(s), 18'o1, 18'o0, 6'o77, 6'o77, 0);
      step("R8 flag all low",  1, GRP | 18'(s), 18'o1, 18'o0, 6'o00, 6'o77, 0);
      step("R9 switch one low",  1, GRP | 18'(s << 3), 18'o1, 18'o0, 6'o77, 6'o57, 0);
      step("R9 switch all low",  1, GRP | 18'(s << 3), 18'o1, 18'o0, 6'o77, 6'o00, 0);
    end
    step("R11 invert true",    1, GRP | 18'o010400, 18'o400000, 18'o0, 6'o77, 6'o77, 0);
    step("R10 or of tests",    1, GRP | 18'o000601, 18'o000001, 18'o0, 6'o76, 6'o77, 0);

    for (int k = 0; k < 600; k++) begin
      logic [17:0] w;
      logic [17:0] a;
      w = 18'($urandom);
      if ($urandom_range(9) < 7) w = GRP | 18'(w[12:0]);
      case ($urandom_range(3))
        0:       a = 18'o0;
        1:       a = 18'o777777;
        default: a = 18'($urandom);
      endcase
      step("R10 random", 1'($urandom_range(7) != 0), w, a, 18'($urandom),
           6'($urandom & $urandom), 6'($urandom & $urandom),
           1'($urandom_range(3) == 0));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule